// File: doc/BRIEF.md
# I2C Status and Interrupt Flags

This block keeps the status flags and the interrupt request of an I2C controller that can work as master or as slave. It watches sampled SCL and SDA itself, finds START and STOP conditions on them and keeps a bus-busy flag from these conditions. A byte and address engine outside the block sends it single-cycle strobes. These strobes report the start and end of a byte, the end of the acknowledge bit, address matches, lost arbitration and SMBus timeouts. With an address match comes the received R/W bit.

Software reads one packed status byte. It clears the sticky flags by writing ones to the status register, or by writing the control register, which clears the addressed-as-slave flag as a side effect. A fast-acknowledge mode input moves the byte-end interrupt to before the acknowledge bit. Software then has time to choose the ACK value.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset the status byte reads transfer-complete (bit 7) = 1, bit 0 = `rxak`, and all other bits 0. `irq` is 0.
- R2: Bus-busy (bit 5) becomes 1 three clock edges after SDA falls while SCL is high (START). It becomes 0 three edges after SDA rises while SCL is high (STOP). SDA changes while SCL is low leave it unchanged.
- R3: Arbitration-lost (bit 4) is set by `arb_lost_stb`. Only a status write with bit 4 = 1 clears it. Status writes with bit 4 = 0 and control writes leave it set.
- R4: Addressed-as-slave (bit 6) is set by `match_pri`. It is also set by `match_gc` when `gc_en` = 1, by `match_sec` when `sec_en` = 1, and by `match_alert` when `alert_en` = 1. A match strobe whose enable is 0 has no effect on bit 6, bit 2 or bit 1.
- R5: Any control write (`reg_wr`=1, `reg_sel`=1) clears bit 6, whatever the data, unless a valid match arrives in the same cycle. Status writes do not clear bit 6.
- R6: Slave read/write (bit 2) takes the value of `rw_bit` on every valid match (0 = master writes, 1 = master reads) and holds it otherwise.
- R7: The interrupt flag (bit 1) is set by a valid match, by `arb_lost_stb` and by `to_scl_low_stb`. `to_scl_high_stb` and `to_sda_high_stb` do not set it.
- R8: With `fast_ack` = 0, `ack_done_stb` sets bit 1 and `data_done_stb` does not. With `fast_ack` = 1 it is the other way round.
- R9: Transfer-complete (bit 7) becomes 0 after `byte_start_stb` and 1 after `data_done_stb`.
- R10: A status write with bit 1 = 1 clears the interrupt flag. If a set source arrives in the same cycle, the flag stays 1. Arbitration-lost follows the same rule with bit 4.
- R11: `irq` is 1 exactly when the interrupt flag is 1 and `int_en` is 1.
- R12: Status writes do not change bits 7, 6, 5, 3, 2 or 0. Bit 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| byte_start_stb | input | 1 | A byte begins shifting |
| data_done_stb | input | 1 | Eighth data bit finished, before ACK |
| ack_done_stb | input | 1 | ACK/NACK bit finished |
| fast_ack | input | 1 | 1: byte interrupt before the ACK bit |
| match_pri | input | 1 | Primary address matched |
| match_gc | input | 1 | General call address received |
| match_sec | input | 1 | Second address matched |
| match_alert | input | 1 | SMBus alert response address received |
| gc_en | input | 1 | Enable for general call match |
| sec_en | input | 1 | Enable for second address match |
| alert_en | input | 1 | Enable for alert response match |
| rw_bit | input | 1 | R/W bit of the calling address |
| arb_lost_stb | input | 1 | Arbitration lost |
| to_scl_low_stb | input | 1 | SCL low timeout |
| to_scl_high_stb | input | 1 | SCL high timeout |
| to_sda_high_stb | input | 1 | SDA high timeout |
| rxak | input | 1 | Received acknowledge, 0 = ACK |
| int_en | input | 1 | Interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status register, 1 = control register |
| reg_wdata | input | 8 | Write data |
| stat_rdata | output | 8 | Packed status byte |
| irq | output | 1 | Interrupt request |

## Verification
A flag stuck in a wrong state appears on `stat_rdata` one edge after the strobe or write that should have moved it. The exception is bus-busy, which trails the lines by three edges through the synchronizer and edge detector. A set/clear priority error therefore shows in the cycle after a colliding write. A wrong fast-ack selection shows as an interrupt flag raised one strobe early or late. A mis-gated match shows as changes in bits 6, 2 and 1 together. `irq` follows the interrupt flag in the same cycle, so a gating fault appears as soon as `int_en` toggles.

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       byte_start_stb,
  input  logic       data_done_stb,
  input  logic       ack_done_stb,
  input  logic       fast_ack,
  input  logic       match_pri,
  input  logic       match_gc,
  input  logic       match_sec,
  input  logic       match_alert,
  input  logic       gc_en,
  input  logic       sec_en,
  input  logic       alert_en,
  input  logic       rw_bit,
  input  logic       arb_lost_stb,
  input  logic       to_scl_low_stb,
  input  logic       to_scl_high_stb,
  input  logic       to_sda_high_stb,
  input  logic       rxak,
  input  logic       int_en,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] stat_rdata,
  output logic       irq
);

  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic tcf, aas, busy, arbl, srw, iif;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_q <= sda_s;
    end

  wire scl_hi    = scl_s & scl_q;
  wire start_det = scl_hi &  sda_q & ~sda_s;
  wire stop_det  = scl_hi & ~sda_q &  sda_s;

  wire match_ok = match_pri | (match_gc & gc_en) | (match_sec & sec_en) | (match_alert & alert_en);
  wire ctl_wr   = reg_wr &  reg_sel;
  wire st_wr    = reg_wr & ~reg_sel;
  wire byte_irq = fast_ack ? data_done_stb : ack_done_stb;
  wire iif_set  = match_ok | arb_lost_stb | to_scl_low_stb | byte_irq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tcf <= 1'b1; aas <= 1'b0; busy <= 1'b0;
      arbl <= 1'b0; srw <= 1'b0; iif <= 1'b0;
    end else begin
      if (start_det)           busy <= 1'b1;
      else if (stop_det)       busy <= 1'b0;
      if (match_ok)            aas <= 1'b1;
      else if (ctl_wr)         aas <= 1'b0;
      if (match_ok)            srw <= rw_bit;
      if (arb_lost_stb)        arbl <= 1'b1;
      else if (st_wr && reg_wdata[4]) arbl <= 1'b0;
      if (iif_set)             iif <= 1'b1;
      else if (st_wr && reg_wdata[1]) iif <= 1'b0;
      if (data_done_stb)       tcf <= 1'b1;
      else if (byte_start_stb) tcf <= 1'b0;
    end

  assign stat_rdata = {tcf, aas, busy, arbl, 1'b0, srw, iif, rxak};
  assign irq        = iif & int_en;

  // R2
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> stat_rdata[5]);
  // R2
  busy_off_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !stat_rdata[5]);
  // R3
  arbl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[4] && !(st_wr && reg_wdata[4])) |=> stat_rdata[4]);
  // R5
  aas_ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !match_ok) |=> !stat_rdata[6]);
  // R7
  hi_timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rdata[1] && !iif_set && (to_scl_high_stb || to_sda_high_stb)) |=> !stat_rdata[1]);
  // R10
  iif_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iif_set && st_wr && reg_wdata[1]) |=> stat_rdata[1]);
  // R9
  tcf_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_start_stb && !data_done_stb) |=> !stat_rdata[7]);

endmodule

// File: tb/i2c_stat_flags_tb.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb;
  logic clk = 0, rst_n = 0;
  logic scl_in = 1, sda_in = 1;
  logic byte_start_stb = 0, data_done_stb = 0, ack_done_stb = 0, fast_ack = 0;
  logic match_pri = 0, match_gc = 0, match_sec = 0, match_alert = 0;
  logic gc_en = 0, sec_en = 0, alert_en = 0, rw_bit = 0, arb_lost_stb = 0;
  logic to_scl_low_stb = 0, to_scl_high_stb = 0, to_sda_high_stb = 0;
  logic rxak = 0, int_en = 0, reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] stat_rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic e_tcf = 1, e_aas = 0, e_arbl = 0, e_srw = 0, e_iif = 0;

  always #4 clk = ~clk;

  i2c_stat_flags u_dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(logic busy_v);
    return {e_tcf, e_aas, busy_v, e_arbl, 1'b0, e_srw, e_iif, rxak};
  endfunction

  task automatic clear_in();
    {byte_start_stb, data_done_stb, ack_done_stb} = 0;
    {match_pri, match_gc, match_sec, match_alert, arb_lost_stb} = 0;
    {to_scl_low_stb, to_scl_high_stb, to_sda_high_stb, reg_wr, reg_sel} = 0;
    reg_wdata = 0;
  endtask

  task automatic cyc(string tag);
    logic ok, st, ct, bi, is;
    ok = match_pri | (match_gc & gc_en) | (match_sec & sec_en) | (match_alert & alert_en);
    st = reg_wr & ~reg_sel; ct = reg_wr & reg_sel;
    bi = fast_ack ? data_done_stb : ack_done_stb;
    is = ok | arb_lost_stb | to_scl_low_stb | bi;
    @(posedge clk); @(negedge clk);
    if (ok) begin e_aas = 1; e_srw = rw_bit; end else if (ct) e_aas = 0;
    if (arb_lost_stb) e_arbl = 1; else if (st && reg_wdata[4]) e_arbl = 0;
    if (is) e_iif = 1; else if (st && reg_wdata[1]) e_iif = 0;
    if (data_done_stb) e_tcf = 1; else if (byte_start_stb) e_tcf = 0;
    clear_in();
    chk(tag, stat_rdata & 8'hDF, exp_stat(1'b0) & 8'hDF);
    chk("R11", {7'd0, irq}, {7'd0, e_iif & int_en});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk("R1", stat_rdata, 8'h80); chk("R1", {7'd0, irq}, 8'd0);
    rst_n = 1; @(negedge clk);
    // R2 START latency and STOP, SDA toggle under SCL low
    sda_in = 0;
    repeat (2) @(negedge clk); chk("R2", {7'd0, stat_rdata[5]}, 8'd0);
    @(negedge clk); chk("R2", {7'd0, stat_rdata[5]}, 8'd1);
    scl_in = 0; repeat (3) @(negedge clk); sda_in = 1; repeat (3) @(negedge clk);
    sda_in = 0; repeat (3) @(negedge clk);
    chk("R2", {7'd0, stat_rdata[5]}, 8'd1);
    scl_in = 1; repeat (3) @(negedge clk); sda_in = 1;
    repeat (3) @(negedge clk); chk("R2", {7'd0, stat_rdata[5]}, 8'd0);
    // R4 disabled general call ignored, then enabled
    rw_bit = 1; match_gc = 1; cyc("R4");
    gc_en = 1; match_gc = 1; rw_bit = 1; cyc("R6");
    // R12 status write leaves read-only bits
    reg_wr = 1; reg_wdata = 8'hED; cyc("R12");
    // R5 control write clears aas
    reg_wr = 1; reg_sel = 1; reg_wdata = 8'h00; cyc("R5");
    // R10 clear iif
    reg_wr = 1; reg_wdata = 8'h02; cyc("R10");
    // R7 high timeouts quiet, low timeout sets
    to_scl_high_stb = 1; to_sda_high_stb = 1; cyc("R7");
    to_scl_low_stb = 1; cyc("R7");
    // R3 arbitration sticky, set wins over clear (R10)
    int_en = 1;
    arb_lost_stb = 1; reg_wr = 1; reg_wdata = 8'h12; cyc("R10");
    reg_wr = 1; reg_wdata = 8'hEF; cyc("R3");
    reg_wr = 1; reg_sel = 1; reg_wdata = 8'hFF; cyc("R3");
    reg_wr = 1; reg_wdata = 8'h12; cyc("R3");
    // R8 fast_ack timing, R9 transfer complete
    fast_ack = 1; byte_start_stb = 1; cyc("R9");
    ack_done_stb = 1; cyc("R8");
    data_done_stb = 1; cyc("R8");
    reg_wr = 1; reg_wdata = 8'h02; cyc("R10");
    fast_ack = 0; data_done_stb = 1; cyc("R8");
    ack_done_stb = 1; cyc("R8");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      {gc_en, sec_en, alert_en, fast_ack, int_en, rxak} = 6'($urandom);
      rw_bit = 1'($urandom);
      if (r < 8) match_pri = 1;
      else if (r < 14) match_gc = 1;
      else if (r < 20) match_sec = 1;
      else if (r < 26) match_alert = 1;
      else if (r < 32) arb_lost_stb = 1;
      else if (r < 40) {to_scl_low_stb, to_scl_high_stb, to_sda_high_stb} = 3'($urandom);
      else if (r < 52) {byte_start_stb, data_done_stb, ack_done_stb} = 3'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        reg_wr = 1; reg_sel = 1'($urandom); reg_wdata = 8'($urandom);
      end
      cyc("R12");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule